// File: doc/BRIEF.md
# Dual-Mode Operation Reset Controller

This block decides when a small processor subsystem enters its reset state. It handles two levels of reset. The configuration-level reset clears everything, including the block's own mode setting, and it acts at once. The operation-level reset is softer, and its timing depends on a mode flag that software writes. In immediate mode, an accepted request drives the operation reset straight away, whether or not a transfer is running. In quiesce mode, the block first raises a sleep request on every internal bus. It drives the reset only after the buses report that they are idle, so no transfer is cut off partway.

The request and idle inputs are asynchronous, and each passes through a two-flop synchronizer before any logic uses it. The configuration reset request drives both reset outputs low at once, without waiting for a clock, and releases them in step with the clock. One bus port is the DMA path. That path halts as soon as a request is accepted, so its idle report is left out of the combined acknowledge. A two-bit status output shows the controller's phase.

Top module: `rstq_ctrl`

## Requirements
- R1: A low level on `init_req_n` drives `init_rst_n` and `op_rst_n` low at once, with no clock edge needed. Once `init_req_n` and `rst_n` are both high again, `init_rst_n` stays low after the first rising edge and goes high after the second.
- R2: The configuration reset returns `sync_mode_o` to 0 (immediate mode), `state_o` to 0 and all `sleep_req` bits to 0, and it does so even while a quiesce wait is pending. The next operation request after it is then handled in immediate mode.
- R3: A cycle with `cfg_we` high loads bit 7 of `cfg_wdata` into the mode flag. A value of 1 selects quiesce mode and 0 selects immediate mode. The other bits have no effect. The new value shows on `sync_mode_o` after that clock edge.
- R4: A rising edge on `op_req` is accepted on the third rising clock edge after it, counting the two synchronizer stages and the edge detector. In immediate mode, `state_o` then becomes 2 and `op_rst_n` goes low, `sleep_req` stays 0, and bus activity has no effect.
- R5: In quiesce mode, an accepted request sets `state_o` to 1 and raises every `sleep_req` bit, while `op_rst_n` stays high. The sleep requests remain high through the reset phase that follows.
- R6: During the wait, the block moves to `state_o` = 2 on the first edge at which the synchronized AND of the counted idle inputs is high. A change on `bus_idle` reaches that decision on the third edge after it.
- R7: The idle input at index `DMA_BUS` (default 2) is left out of the AND, so a low level there never delays entry into reset.
- R8: An `op_req` rising edge that arrives while `state_o` is 1 or 2 is dropped, and no second reset follows when the block returns to run.
- R9: `op_rst_n` stays low for exactly `HOLD_CYCLES` clock cycles (default 16). The block then returns `state_o` to 0 and drops all sleep requests in the same cycle.
- R10: `state_o` encodes run as 0, quiesce wait as 1 and in-reset as 2. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| init_req_n | input | 1 | Configuration-level reset request, active low, asynchronous |
| op_req | input | 1 | Operation-level reset request, asynchronous, accepted on its rising edge |
| bus_idle | input | NUM_BUS | Per-bus idle/sleep acknowledge, asynchronous |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | CFG_W | Control register write data; bit MODE_BIT is the mode flag |
| init_rst_n | output | 1 | Configuration reset output, active low |
| op_rst_n | output | 1 | Operation reset output, active low |
| sleep_req | output | NUM_BUS | Sleep request to each internal bus |
| sync_mode_o | output | 1 | Current mode flag (1 = quiesce) |
| state_o | output | 2 | Phase: 0 run, 1 waiting for sleep, 2 in reset |

## Verification
The operation request is applied in immediate mode while the buses report busy. This shows whether the reset ignores bus activity and whether the hold length is right. In quiesce mode the idle inputs are raised in stages: first with a counted bus still busy, then with only the DMA input low. This separates correct AND masking from early or late entry, and it pins down the exact edge on which reset starts. Further requests are sent during the wait and during the reset to show that they are dropped. Finally, a configuration reset arrives in the middle of a wait, and the next request must be handled in immediate mode.

// File: rtl/rstq_pkg.sv
package rstq_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_RST  = 2'd2
  } rstq_state_e;
endpackage

// File: rtl/rstq_sync.sv
module rstq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/rstq_rst_sync.sv
module rstq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/rstq_fsm.sv
module rstq_fsm
  import rstq_pkg::*;
#(
  parameter int HOLD_CYCLES = 16,
  localparam int CNT_W      = $clog2(HOLD_CYCLES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_pulse,
  input  logic        sync_mode,
  input  logic        all_idle,
  output rstq_state_e state_o,
  output logic        sleep_o,
  output logic        in_rst_o
);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

  rstq_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sleep_q, sleep_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sleep_d = sleep_q;
    unique case (state_q)
      ST_RUN: begin
        if (req_pulse) begin
          if (sync_mode) begin
            state_d = ST_WAIT;
            sleep_d = 1'b1;
          end else begin
            state_d = ST_RST;
            cnt_d   = HOLD_LAST;
          end
        end
      end
      ST_WAIT: begin
        if (all_idle) begin
          state_d = ST_RST;
          cnt_d   = HOLD_LAST;
        end
      end
      ST_RST: begin
        if (cnt_q == '0) begin
          state_d = ST_RUN;
          sleep_d = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        state_d = ST_RUN;
        sleep_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      sleep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sleep_q <= sleep_d;
    end
  end

  assign state_o  = state_q;
  assign sleep_o  = sleep_q;
  assign in_rst_o = (state_q == ST_RST);
endmodule

// File: rtl/rstq_ctrl.sv
module rstq_ctrl
  import rstq_pkg::*;
#(
  parameter int NUM_BUS     = 3,
  parameter int DMA_BUS     = 2,
  parameter int HOLD_CYCLES = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CFG_W       = 8,
  parameter int MODE_BIT    = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_req_n,
  input  logic               op_req,
  input  logic [NUM_BUS-1:0] bus_idle,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic               init_rst_n,
  output logic               op_rst_n,
  output logic [NUM_BUS-1:0] sleep_req,
  output logic               sync_mode_o,
  output logic [1:0]         state_o
);
  localparam logic [NUM_BUS-1:0] IDLE_IGNORE =
    (DMA_BUS < NUM_BUS) ? (NUM_BUS'(1) << DMA_BUS) : '0;

  logic               sys_rst_n;
  logic               req_s, req_d_q, req_pulse;
  logic [NUM_BUS-1:0] idle_s;
  logic               all_idle;
  logic               mode_q, mode_d;
  logic               sleep_bit, in_rst;
  rstq_state_e        fsm_state;

  rstq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n & init_req_n),
    .srst_n (sys_rst_n)
  );

  rstq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .d     (op_req),
    .q     (req_s)
  );

  rstq_sync #(.W(NUM_BUS), .STAGES(SYNC_STAGES)) u_idle_sync (
    .clk   (clk),
    .rst_n (sys_rst_n),
    .d     (bus_idle),
    .q     (idle_s)
  );

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) req_d_q <= 1'b0;
    else            req_d_q <= req_s;
  end

  assign req_pulse = req_s & ~req_d_q;
  assign all_idle  = &(idle_s | IDLE_IGNORE);

  always_comb begin
    mode_d = mode_q;
    if (cfg_we) mode_d = cfg_wdata[MODE_BIT];
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) mode_q <= 1'b0;
    else            mode_q <= mode_d;
  end

  rstq_fsm #(.HOLD_CYCLES(HOLD_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (sys_rst_n),
    .req_pulse (req_pulse),
    .sync_mode (mode_q),
    .all_idle  (all_idle),
    .state_o   (fsm_state),
    .sleep_o   (sleep_bit),
    .in_rst_o  (in_rst)
  );

  assign init_rst_n  = sys_rst_n;
  assign op_rst_n    = sys_rst_n & ~in_rst;
  assign sleep_req   = {NUM_BUS{sleep_bit}};
  assign sync_mode_o = mode_q;
  assign state_o     = fsm_state;
endmodule

// File: rtl/rstq_ctrl_chk.sv
module rstq_ctrl_chk #(
  parameter int NUM_BUS     = 3,
  parameter int HOLD_CYCLES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               init_rst_n,
  input logic               op_rst_n,
  input logic [NUM_BUS-1:0] sleep_req,
  input logic               sync_mode_o,
  input logic [1:0]         state_o
);
  logic        live_n;
  logic [31:0] hold_cnt;

  assign live_n = rst_n & init_rst_n;

  always_ff @(posedge clk or negedge live_n) begin
    if (!live_n)               hold_cnt <= '0;
    else if (state_o == 2'd2)  hold_cnt <= hold_cnt + 1;
    else                       hold_cnt <= '0;
  end

  p_status_legal_r10: assert property (@(posedge clk) disable iff (!live_n)
    state_o != 2'd3);

  p_wait_sleep_r5: assert property (@(posedge clk) disable iff (!live_n)
    (state_o == 2'd1) |-> ((&sleep_req) && op_rst_n));

  p_imm_entry_r4: assert property (@(posedge clk) disable iff (!live_n)
    ($past(state_o) == 2'd0 && state_o == 2'd2) |-> (sleep_req == '0));

  p_hold_len_r9: assert property (@(posedge clk) disable iff (!live_n)
    ($past(state_o) == 2'd2 && state_o == 2'd0) |-> (hold_cnt == HOLD_CYCLES));

  p_run_quiet_r9: assert property (@(posedge clk) disable iff (!live_n)
    (state_o == 2'd0) |-> (sleep_req == '0 && op_rst_n));

  p_wait_exit_r6: assert property (@(posedge clk) disable iff (!live_n)
    (state_o == 2'd1) |=> (state_o != 2'd0));

  p_mode_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_rst_n) |-> (!sync_mode_o && state_o == 2'd0));
endmodule

bind rstq_ctrl rstq_ctrl_chk #(.NUM_BUS(NUM_BUS), .HOLD_CYCLES(HOLD_CYCLES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init_rst_n  (init_rst_n),
  .op_rst_n    (op_rst_n),
  .sleep_req   (sleep_req),
  .sync_mode_o (sync_mode_o),
  .state_o     (state_o)
);

// File: tb/rstq_ctrl_tb.sv
module rstq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 3;
  localparam int HOLD       = 16;

  logic          clk = 1'b0;
  logic          rst_n, init_req_n, op_req, cfg_we;
  logic [NB-1:0] bus_idle;
  logic [7:0]    cfg_wdata;
  logic          init_rst_n, op_rst_n, sync_mode_o;
  logic [NB-1:0] sleep_req;
  logic [1:0]    state_o;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rstq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .init_req_n(init_req_n), .op_req(op_req),
    .bus_idle(bus_idle), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .init_rst_n(init_rst_n), .op_rst_n(op_rst_n), .sleep_req(sleep_req),
    .sync_mode_o(sync_mode_o), .state_o(state_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on each rising edge
  bit        ms0, ms1, mmode, msl, mr0, mr1, mr2, rise, aidle;
  int        mst, mcnt;
  bit [NB-1:0] mi0, mi1;

  always @(posedge clk) begin
    cyc++;
    if (!(rst_n && init_req_n)) begin
      ms0 = 0; ms1 = 0; mst = 0; mcnt = 0; msl = 0; mmode = 0;
      mr0 = 0; mr1 = 0; mr2 = 0; mi0 = '0; mi1 = '0;
    end else begin
      if (ms1) begin
        rise  = mr1 && !mr2;
        aidle = &(mi1 | 3'b100);
        case (mst)
          0: if (rise) begin
               if (mmode) begin mst = 1; msl = 1; end
               else begin mst = 2; mcnt = HOLD - 1; end
             end
          1: if (aidle) begin mst = 2; mcnt = HOLD - 1; end
          default: if (mcnt == 0) begin mst = 0; msl = 0; end
                   else mcnt--;
        endcase
        if (cfg_we) mmode = cfg_wdata[7];
        mr2 = mr1; mr1 = mr0; mr0 = op_req;
        mi1 = mi0; mi0 = bus_idle;
      end
      ms1 = ms0; ms0 = 1;
    end
    #1;
    if (cyc > 2) begin
      chk("R1 init_rst_n", init_rst_n, ms1);
      chk("R9 op_rst_n", op_rst_n, (ms1 && mst != 2) ? 1 : 0);
      chk("R10 state", state_o, mst);
      chk("R5 sleep", sleep_req, msl ? 7 : 0);
      chk("R3 mode", sync_mode_o, mmode);
    end
  end

  always @(posedge clk) begin
    if (cyc > 5000) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    int lowcnt;
    bit sawsl;
    rst_n = 0; init_req_n = 1; op_req = 0; cfg_we = 0;
    cfg_wdata = '0; bus_idle = '0;
    step(3);
    rst_n = 1;
    step(4);
    chk("R1 reset released", init_rst_n, 1);
    chk("R2 reset state", state_o, 0);
    chk("R2 reset mode", sync_mode_o, 0);
    chk("R2 reset sleep", sleep_req, 0);

    // Immediate mode, buses busy: R4 and R9 hold length
    op_req = 1; lowcnt = 0; sawsl = 0;
    for (int i = 0; i < 40; i++) begin
      step(1);
      if (i == 3) op_req = 0;
      if (!op_rst_n) lowcnt++;
      if (sleep_req != 0) sawsl = 1;
    end
    chk("R9 hold cycles", lowcnt, HOLD);
    chk("R4 no sleep in immediate mode", sawsl, 0);
    chk("R9 back to run", state_o, 0);

    // Mode writes: only bit 7 matters (R3)
    cfg_we = 1; cfg_wdata = 8'h7F; step(1); cfg_we = 0;
    chk("R3 low bits ignored", sync_mode_o, 0);
    cfg_we = 1; cfg_wdata = 8'h80; step(1); cfg_we = 0;
    chk("R3 quiesce selected", sync_mode_o, 1);

    // Quiesce request (R5)
    bus_idle = '0; op_req = 1; step(3); op_req = 0; step(3);
    chk("R5 wait state", state_o, 1);
    chk("R5 sleep all", sleep_req, 7);
    chk("R5 op reset held off", op_rst_n, 1);

    // Second request during wait (R8)
    op_req = 1; step(3); op_req = 0; step(3);
    chk("R8 still waiting", state_o, 1);

    // Counted bus still busy (R6), then only DMA busy (R7)
    bus_idle = 3'b001; step(10);
    chk("R6 waits for bus 1", state_o, 1);
    bus_idle = 3'b011; step(2);
    chk("R6 not early", state_o, 1);
    step(1);
    chk("R7 DMA idle ignored", state_o, 2);
    chk("R5 sleep kept in reset", sleep_req, 7);
    op_req = 1; step(3); op_req = 0; step(25);
    chk("R8 no second reset", state_o, 0);
    chk("R9 sleep dropped", sleep_req, 0);

    // Configuration reset during a pending wait (R2, R1)
    bus_idle = '0; op_req = 1; step(3); op_req = 0; step(3);
    chk("R2 precondition wait", state_o, 1);
    init_req_n = 0; #1;
    chk("R1 init async", init_rst_n, 0);
    chk("R1 op async", op_rst_n, 0);
    chk("R2 state cleared", state_o, 0);
    chk("R2 sleep cleared", sleep_req, 0);
    chk("R2 mode cleared", sync_mode_o, 0);
    step(2);
    init_req_n = 1; step(1);
    chk("R1 release edge one", init_rst_n, 0);
    step(1);
    chk("R1 release edge two", init_rst_n, 1);
    op_req = 1; step(3); op_req = 0; step(2);
    chk("R2 immediate after init", state_o, 2);
    chk("R4 no sleep", sleep_req, 0);
    step(30);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule